// File: doc/BRIEF.md
# Vectored 64-Input Interrupt Controller

This block gathers 64 interrupt request lines and routes each one to one of eight destination outputs: the normal interrupt line, the fast interrupt line, and six auxiliary lines. Every input has its own configuration byte. The byte sets whether the input is enabled, which destination it drives, and how it triggers. An input can trigger on an active-high level, on a rising edge, on a falling edge, or on either edge.

Edge events are caught after a two-stage synchronizer and held in status bits. Software clears those bits by writing ones to them. For the normal interrupt line, the block also gives a vector: the number of the winning pending source. Priority among sources is either fixed, where the lowest number wins, or rotating. In rotating mode the search starts one place past the source that was last handed out by a vector read.

Software reaches everything through a simple word-wide register port. The port has a byte address, per-byte write strobes and a read strobe.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After reset all eight destination outputs are low. The vector register (offset 0x00) reads 63, every configuration byte reads 0, and both priority registers read 0.
- R2: The configuration byte of source n sits at byte offset 0x40+n, which is byte lane n%4 of word 0x40+4*(n/4). Bits [2:0] give the destination, bit 3 enables the source, bit 5 selects rising edge and bit 6 selects falling edge. Bits 4 and 7 always read 0, and only the lanes whose write strobe is set are written.
- R3: With bits 5 and 6 both clear, the source is active-high level. Its status bit follows the input two clock edges after the input changes, and writes to that status bit have no effect.
- R4: A rising-edge source sets its status bit three edges after a 0-to-1 input change. The bit stays set after the input falls. Writing 1 to the bit clears it, and writing 0 leaves it set. Status word 0x80 holds sources 0 to 31 and word 0x84 holds sources 32 to 63, with source n at bit n%32.
- R5: A falling-edge source latches a 1-to-0 input change and ignores a 0-to-1 change.
- R6: A disabled source still shows its status, but it drives no output and is never chosen as the vector.
- R7: A destination code of 0 drives irq_o, 1 drives fiq_o, and codes 2 to 7 drive aux_o[0] to aux_o[5]. Each output is high while any enabled source routed to it has its status set.
- R8: When bit 6 of the normal priority register (offset 0x20) is 0, the vector is the lowest-numbered pending enabled source routed to irq_o. Vector reads do not change that order.
- R9: When bit 6 of the normal priority register is 1, the search starts at the pointer plus one and wraps modulo 64. The pointer is bits [5:0] of that register. A vector read while irq_o is high loads the returned number into the pointer, and a write to byte lane 0 sets the whole register.
- R10: With nothing pending, the vector reads 63. A real request from source 63 also reads 63, but it is marked by bit 31 of status word 0x84.
- R11: The fast priority register (offset 0x24) keeps bits [6:0] as written and has no effect on the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous interrupt request lines |
| bus_addr | input | 8 | Byte address of the register access; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (marks a vector read as a grant) |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| aux_o | output | 6 | Auxiliary destination lines |

## Verification
The bench goes after the empty-vector ambiguity. It shows that an idle controller and a live source-63 request both read 63, and that only the status bit tells them apart. A design that returned some other idle code, or that failed to latch source 63, would be caught there.

Rotating priority is walked through a full wrap-around from source 50 back to source 5. A pointer that was not updated on the vector read, or that did not wrap, would hand out the same source twice.

The write-one-to-clear path is tried with a zero write, with a one write, and against a level source. A design that cleared on any write, or that let writes disturb level inputs, would show a stale or missing status bit.

Masked edge sources are pulsed while disabled and then enabled. This checks that latching goes on even while the output stays quiet.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;

    localparam int NUM_SRC   = 64;
    localparam int ID_W      = $clog2(NUM_SRC);
    localparam int NUM_DEST  = 8;
    localparam int DEST_W    = $clog2(NUM_DEST);
    localparam int NUM_AUX   = NUM_DEST - 2;
    localparam int SYNC_LEN  = 2;

    // Register word indexes (byte address bits [7:2]).
    localparam logic [5:0] WI_VEC   = 6'd0;
    localparam logic [5:0] WI_PIRQ  = 6'd8;
    localparam logic [5:0] WI_PFIQ  = 6'd9;
    localparam logic [1:0] CFG_PAGE = 2'b01;
    localparam logic [5:0] WI_STAT  = 6'd32;

    localparam logic [DEST_W-1:0] DST_IRQ = DEST_W'(0);
    localparam logic [DEST_W-1:0] DST_FIQ = DEST_W'(1);

    typedef struct packed {
        logic              fall;
        logic              rise;
        logic              en;
        logic [DEST_W-1:0] dest;
    } src_cfg_t;

    typedef struct packed {
        logic            rotate;
        logic [ID_W-1:0] ptr;
    } prio_ctl_t;

    function automatic src_cfg_t cfg_unpack(input logic [7:0] b);
        src_cfg_t c;
        c.fall = b[6];
        c.rise = b[5];
        c.en   = b[3];
        c.dest = b[DEST_W-1:0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_pack(input src_cfg_t c);
        return {1'b0, c.fall, c.rise, 1'b0, c.en, c.dest};
    endfunction

endpackage

// File: rtl/intr_src_cell.sv
module intr_src_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic edge_mode_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic clr_i,
    output logic stat_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   held_q;
    logic                   synced;
    logic                   evt;

    assign synced = sync_q[SYNC_STAGES-1];
    assign evt    = (rise_i & synced & ~prev_q) | (fall_i & ~synced & prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            prev_q <= synced;
            if (!edge_mode_i)
                held_q <= 1'b0;
            else if (evt)
                held_q <= 1'b1;
            else if (clr_i)
                held_q <= 1'b0;
        end
    end

    assign stat_o = edge_mode_i ? held_q : synced;

endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
    parameter int N = 64
) (
    input  logic [N-1:0]         pend_i,
    input  logic                 rotate_i,
    input  logic [$clog2(N)-1:0] ptr_i,
    output logic                 any_o,
    output logic [$clog2(N)-1:0] vec_o
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] start;
    logic [IW-1:0] idx;
    logic          found;

    assign any_o = |pend_i;
    assign start = rotate_i ? ptr_i + 1'b1 : '0;

    always_comb begin
        vec_o = IW'(N - 1);
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            idx = start + IW'(i);
            if (!found && pend_i[idx]) begin
                vec_o = idx;
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
    import intr_vec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [NUM_AUX-1:0] aux_o
);
    src_cfg_t           cfg_q [NUM_SRC];
    prio_ctl_t          irq_prio;
    prio_ctl_t          fiq_prio;
    logic [NUM_SRC-1:0] stat;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] edge_mode;
    logic [NUM_SRC-1:0] pend_irq;
    logic [NUM_DEST-1:0] dest_hit;
    logic [ID_W-1:0]    vec;
    logic               irq_any;
    logic [5:0]         wsel;
    logic               cfg_sel;

    assign wsel    = bus_addr[7:2];
    assign cfg_sel = (bus_addr[7:6] == CFG_PAGE);

    // Per-source synchronizer, edge latch and write-one clear decode.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [5:0] SW = 6'(WI_STAT + g / 32);
        assign edge_mode[g] = cfg_q[g].rise | cfg_q[g].fall;
        assign clr[g] = bus_wr && (wsel == SW) && bus_be[(g % 32) / 8]
                        && bus_wdata[g % 32];
        assign pend_irq[g] = stat[g] && cfg_q[g].en && (cfg_q[g].dest == DST_IRQ);

        intr_src_cell #(.SYNC_STAGES(SYNC_LEN)) cell_i (
            .clk        (clk),
            .rst        (rst),
            .raw_i      (src_i[g]),
            .edge_mode_i(edge_mode[g]),
            .rise_i     (cfg_q[g].rise),
            .fall_i     (cfg_q[g].fall),
            .clr_i      (clr[g]),
            .stat_o     (stat[g])
        );
    end

    intr_prio_pick #(.N(NUM_SRC)) pick_i (
        .pend_i  (pend_irq),
        .rotate_i(irq_prio.rotate),
        .ptr_i   (irq_prio.ptr),
        .any_o   (irq_any),
        .vec_o   (vec)
    );

    // Destination fan-in.
    always_comb begin
        dest_hit = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (stat[i] && cfg_q[i].en)
                dest_hit[cfg_q[i].dest] = 1'b1;
    end

    assign irq_o = dest_hit[0];
    assign fiq_o = dest_hit[1];
    assign aux_o = dest_hit[NUM_DEST-1:2];

    // Configuration bytes.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++)
                cfg_q[i] <= '0;
        end else if (bus_wr && cfg_sel) begin
            for (int j = 0; j < 4; j++)
                if (bus_be[j])
                    cfg_q[{bus_addr[5:2], 2'(j)}] <= cfg_unpack(bus_wdata[8*j +: 8]);
        end
    end

    // Priority control; a software write wins over a grant update.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_prio <= '0;
            fiq_prio <= '0;
        end else begin
            if (bus_wr && wsel == WI_PIRQ && bus_be[0])
                irq_prio <= bus_wdata[ID_W:0];
            else if (bus_rd && wsel == WI_VEC && irq_any)
                irq_prio.ptr <= vec;
            if (bus_wr && wsel == WI_PFIQ && bus_be[0])
                fiq_prio <= bus_wdata[ID_W:0];
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (cfg_sel) begin
            for (int j = 0; j < 4; j++)
                bus_rdata[8*j +: 8] = cfg_pack(cfg_q[{bus_addr[5:2], 2'(j)}]);
        end else begin
            case (wsel)
                WI_VEC:        bus_rdata[ID_W-1:0] = vec;
                WI_PIRQ:       bus_rdata[ID_W:0]   = irq_prio;
                WI_PFIQ:       bus_rdata[ID_W:0]   = fiq_prio;
                WI_STAT:       bus_rdata           = stat[31:0];
                WI_STAT + 6'd1: bus_rdata          = stat[63:32];
                default:       bus_rdata           = '0;
            endcase
        end
    end

endmodule

// File: rtl/intr_vector_ctrl_chk.sv
module intr_vector_ctrl_chk
    import intr_vec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [7:0]         bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               irq_o,
    input logic               irq_any,
    input logic [ID_W-1:0]    vec,
    input logic [ID_W-1:0]    prio_ptr,
    input logic [NUM_SRC-1:0] pend_irq,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] edge_mode,
    input logic [NUM_SRC-1:0] clr
);
    // R10
    vec_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_any |-> vec == ID_W'(NUM_SRC - 1));

    // R8
    vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend_irq[vec]);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_irq == '0) |-> !irq_o);

    // R9
    grant_track_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr[7:2] == 6'd0 && irq_any) |=> prio_ptr == $past(vec));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hold
        // R4
        edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (edge_mode[g] && $past(edge_mode[g]) && $past(stat[g]) && !$past(clr[g]))
            |-> stat[g]);
    end

endmodule

bind intr_vector_ctrl intr_vector_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .irq_o    (irq_o),
    .irq_any  (irq_any),
    .vec      (vec),
    .prio_ptr (irq_prio.ptr),
    .pend_irq (pend_irq),
    .stat     (stat),
    .edge_mode(edge_mode),
    .clr      (clr)
);

// File: tb/intr_vector_ctrl_tb_top.sv
module intr_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;
    logic [5:0]  aux_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_vector_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_i),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o),
        .aux_o    (aux_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_be    = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic set_cfg(input int n, input logic [7:0] b);
        bus_write(8'(8'h40 + (n / 4) * 4), 4'(1 << (n % 4)), 32'(b) << (8 * (n % 4)));
    endtask

    task automatic drive(input int n, input logic v);
        @(negedge clk);
        src_i[n] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "outputs", {24'd0, aux_o, fiq_o, irq_o}, 32'd0);
        bus_read(8'h00, d); chk("R1", "vector", d, 32'd63);
        bus_read(8'h40, d); chk("R1", "cfg word", d, 32'd0);
        bus_read(8'h20, d); chk("R1", "irq prio", d, 32'd0);
        bus_read(8'h24, d); chk("R1", "fiq prio", d, 32'd0);
    endtask

    task automatic t_cfg_rw();
        logic [31:0] d;
        bus_write(8'h44, 4'b0010, 32'hAAAA_FFAA);
        bus_read(8'h44, d); chk("R2", "lane strobe and reserved bits", d, 32'h0000_6F00);
        set_cfg(5, 8'h00);
    endtask

    task automatic t_level();
        logic [31:0] d;
        set_cfg(10, 8'h08);
        drive(10, 1'b1);
        bus_read(8'h80, d); chk("R3", "level status set", d, 32'h0000_0400);
        chk("R3", "irq from level", {31'd0, irq_o}, 32'd1);
        bus_read(8'h00, d); chk("R3", "vector level", d, 32'd10);
        bus_write(8'h80, 4'b1111, 32'h0000_0400);
        bus_read(8'h80, d); chk("R3", "write ignored on level", d, 32'h0000_0400);
        drive(10, 1'b0);
        bus_read(8'h80, d); chk("R3", "level status follows low", d, 32'd0);
        set_cfg(10, 8'h00);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        set_cfg(40, 8'h28);
        drive(40, 1'b1);
        drive(40, 1'b0);
        bus_read(8'h84, d); chk("R4", "rise latched after drop", d, 32'h0000_0100);
        chk("R4", "irq from edge", {31'd0, irq_o}, 32'd1);
        bus_write(8'h84, 4'b1111, 32'h0000_0000);
        bus_read(8'h84, d); chk("R4", "zero write keeps", d, 32'h0000_0100);
        bus_write(8'h84, 4'b1111, 32'h0000_0100);
        bus_read(8'h84, d); chk("R4", "one write clears", d, 32'd0);
        chk("R4", "irq after clear", {31'd0, irq_o}, 32'd0);
        set_cfg(40, 8'h00);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        set_cfg(3, 8'h48);
        drive(3, 1'b1);
        bus_read(8'h80, d); chk("R5", "rise ignored", d, 32'd0);
        drive(3, 1'b0);
        bus_read(8'h80, d); chk("R5", "fall latched", d, 32'h0000_0008);
        bus_write(8'h80, 4'b0001, 32'h0000_0008);
        set_cfg(3, 8'h00);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        set_cfg(20, 8'h20);
        drive(20, 1'b1);
        drive(20, 1'b0);
        bus_read(8'h80, d); chk("R6", "masked status visible", d, 32'h0010_0000);
        chk("R6", "masked irq low", {31'd0, irq_o}, 32'd0);
        bus_read(8'h00, d); chk("R6", "masked vector empty", d, 32'd63);
        set_cfg(20, 8'h28);
        chk("R6", "irq after enable", {31'd0, irq_o}, 32'd1);
        bus_read(8'h00, d); chk("R6", "vector after enable", d, 32'd20);
        bus_write(8'h80, 4'b0100, 32'h0010_0000);
        set_cfg(20, 8'h00);
    endtask

    task automatic t_route();
        set_cfg(7, 8'h08);
        drive(7, 1'b1);
        for (int dst = 0; dst < 8; dst++) begin
            set_cfg(7, 8'(8'h08 | dst));
            chk("R7", $sformatf("route code %0d", dst),
                {24'd0, aux_o, fiq_o, irq_o}, 32'(1 << dst));
        end
        set_cfg(7, 8'h00);
        drive(7, 1'b0);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        set_cfg(5, 8'h08); set_cfg(12, 8'h08); set_cfg(50, 8'h08);
        @(negedge clk); src_i[5] = 1'b1; src_i[12] = 1'b1; src_i[50] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(8'h00, d); chk("R8", "fixed lowest", d, 32'd5);
        bus_read(8'h00, d); chk("R8", "fixed repeat", d, 32'd5);
        set_cfg(5, 8'h00);
        bus_read(8'h00, d); chk("R8", "fixed next", d, 32'd12);
        set_cfg(5, 8'h08);
    endtask

    task automatic t_rotate();
        logic [31:0] d;
        bus_write(8'h20, 4'b0001, 32'h0000_0040);
        bus_read(8'h00, d); chk("R9", "rotate first", d, 32'd5);
        bus_read(8'h00, d); chk("R9", "rotate second", d, 32'd12);
        bus_read(8'h00, d); chk("R9", "rotate third", d, 32'd50);
        bus_read(8'h00, d); chk("R9", "rotate wrap", d, 32'd5);
        bus_read(8'h20, d); chk("R9", "pointer tracks grant", d, 32'h45);
    endtask

    task automatic t_fiq_prio();
        logic [31:0] d;
        bus_write(8'h20, 4'b0001, 32'h0000_0000);
        bus_write(8'h24, 4'b0001, 32'h0000_007F);
        bus_read(8'h24, d); chk("R11", "fiq prio readback", d, 32'h7F);
        bus_read(8'h00, d); chk("R11", "fiq prio no effect", d, 32'd5);
        bus_write(8'h24, 4'b0001, 32'h0);
        set_cfg(5, 8'h00); set_cfg(12, 8'h00); set_cfg(50, 8'h00);
        @(negedge clk); src_i[5] = 1'b0; src_i[12] = 1'b0; src_i[50] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_src63();
        logic [31:0] d;
        bus_read(8'h00, d); chk("R10", "idle vector", d, 32'd63);
        bus_read(8'h84, d); chk("R10", "idle bit31", d, 32'd0);
        set_cfg(63, 8'h08);
        drive(63, 1'b1);
        bus_read(8'h00, d); chk("R10", "source 63 vector", d, 32'd63);
        bus_read(8'h84, d); chk("R10", "source 63 bit31", d, 32'h8000_0000);
        chk("R10", "irq for 63", {31'd0, irq_o}, 32'd1);
        drive(63, 1'b0);
        set_cfg(63, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg_rw();
        t_level();
        t_rise();
        t_fall();
        t_mask();
        t_route();
        t_fixed();
        t_rotate();
        t_fiq_prio();
        t_src63();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule